// File: doc/BRIEF.md
# Supply-Aware Clock Speed Governor

This block decides when a processor core may run from its fast clock and when it has to stay on, or fall back to, the slow clock. It watches a raw low-supply comparator flag and debounces it. It drives three select fields: the low-voltage detect set point, the power-on-reset threshold level, and the clock speed. Raising the clock is always a staged sequence. First the detect set point is programmed to a high level. Then the supply must read good for a programmable number of consecutive cycles. Then the reset threshold is raised. Only on a later cycle is the fast clock selected.

When the comparator reports a dip while the core runs fast, the clock drops on the next edge and the reset threshold returns to its low default on the edge after that. The block then waits for a fresh debounced good supply before it tries again. Keeping the threshold low until the supply is confirmed good avoids a string of resets during a slow power ramp. Removing the enable unwinds the stages one output per cycle until the block is back in its idle slow state.

Top module: `speed_governor`

## Requirements
- R1: After reset the status code is 00, the reset threshold select is 00, the fast clock select is 0 and the detect set point select is 000 (not programmed).
- R2: With the enable high in the idle state, the next edge sets the detect set point to 110 when the pick input is 0 or to 111 when it is 1, and moves the status to 01. The reset threshold select stays at 00.
- R3: In status 01 the reset threshold select changes to 10 (status 10) on the edge that samples the comparator flag clear for the Nth consecutive time, where N is the debounce input, and a value of 0 counts as 1. It stays 00 before that edge.
- R4: A comparator flag sampled high during the debounce window restarts the count. N further consecutive clear samples are then needed.
- R5: The fast clock select is 1 only while the reset threshold select is 10. It rises on the edge after the threshold was raised, provided the flag is clear and the enable is high at that edge. The status is then 11.
- R6: The fast clock select and the reset threshold select never both change on the same edge.
- R7: A flag sampled high while fast clears the fast select on that edge (status 10). The threshold select returns to 00 on the next edge (status 01), whatever the flag does then. A new full debounce follows.
- R8: The status output encodes slow as 00, settling as 01, threshold-raised as 10 and fast as 11.
- R9: With the enable low, the block steps down one stage per edge: fast select off first, then threshold to 00, then status 00 with the detect set point back at 000.
- R10: A flag sampled high in status 10 before the fast clock was selected returns the threshold select to 00 and the status to 01 without selecting the fast clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Allows the governor to climb toward the fast clock |
| vlow_raw | input | 1 | Comparator flag, high while the supply is below the set point |
| pick_top | input | 1 | Chooses detect set point 111 (1) or 110 (0) |
| deb_len | input | CNT_W | Consecutive clear samples needed (0 treated as 1) |
| lvd_sel | output | 3 | Low-voltage detect set point select |
| por_sel | output | 2 | Reset threshold select, 10 is high, 00 is default |
| fast_sel | output | 1 | Fast clock select |
| status | output | 2 | Current stage code |

## Verification
The assertions assume that the comparator flag and the enable are synchronous to the block clock and settle well before each edge. They also assume that the debounce length and the set-point pick change only while the block is held in reset. The bench meets these conditions by driving every input one time unit after a rising edge and by changing the debounce length and pick only between resets. It sweeps every debounce length from 0 to 5 with both picks, and every glitch position inside a four-cycle window.

// File: rtl/speed_governor.sv
module speed_governor #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             vlow_raw,
  input  logic             pick_top,
  input  logic [CNT_W-1:0] deb_len,
  output logic [2:0]       lvd_sel,
  output logic [1:0]       por_sel,
  output logic             fast_sel,
  output logic [1:0]       status
);

  localparam logic [1:0] ST_SLOW   = 2'b00;
  localparam logic [1:0] ST_SETTLE = 2'b01;
  localparam logic [1:0] ST_THRESH = 2'b10;
  localparam logic [1:0] ST_FAST   = 2'b11;
  localparam logic [1:0] POR_LOW   = 2'b00;
  localparam logic [1:0] POR_HIGH  = 2'b10;

  logic [1:0]       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             drop_q;
  logic [2:0]       lvd_q;
  logic [1:0]       por_q;
  logic             fast_q;
  logic [CNT_W:0]   target;
  logic             deb_done;

  assign target   = (deb_len == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, deb_len};
  assign deb_done = ({1'b0, cnt_q} + 1'b1) >= target;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_SLOW;
      cnt_q  <= '0;
      drop_q <= 1'b0;
      lvd_q  <= 3'b000;
      por_q  <= POR_LOW;
      fast_q <= 1'b0;
    end else begin
      case (st_q)
        ST_SLOW: begin
          lvd_q <= 3'b000;
          cnt_q <= '0;
          if (en) begin
            lvd_q <= {2'b11, pick_top};
            st_q  <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (!en) begin
            st_q  <= ST_SLOW;
            lvd_q <= 3'b000;
            cnt_q <= '0;
          end else if (vlow_raw) begin
            cnt_q <= '0;
          end else if (deb_done) begin
            por_q  <= POR_HIGH;
            st_q   <= ST_THRESH;
            drop_q <= 1'b0;
            cnt_q  <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_THRESH: begin
          if (drop_q || !en || vlow_raw) begin
            por_q  <= POR_LOW;
            st_q   <= ST_SETTLE;
            cnt_q  <= '0;
            drop_q <= 1'b0;
          end else begin
            fast_q <= 1'b1;
            st_q   <= ST_FAST;
          end
        end
        default: begin
          if (!en || vlow_raw) begin
            fast_q <= 1'b0;
            drop_q <= 1'b1;
            st_q   <= ST_THRESH;
          end
        end
      endcase
    end
  end

  assign lvd_sel  = lvd_q;
  assign por_sel  = por_q;
  assign fast_sel = fast_q;
  assign status   = st_q;

  AST_FAST_NEEDS_HIGH_POR: assert property (@(posedge clk) disable iff (!rst_n)
    fast_sel |-> por_sel == POR_HIGH); // R5

  AST_POR_BEFORE_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fast_sel) |-> $past(por_sel) == POR_HIGH); // R5

  AST_ONE_SELECT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!$stable(fast_sel) && !$stable(por_sel))); // R6

  AST_HIGH_POR_NEEDS_LVD: assert property (@(posedge clk) disable iff (!rst_n)
    por_sel == POR_HIGH |-> lvd_sel[2:1] == 2'b11); // R2

  AST_POR_RAISE_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (por_sel == POR_HIGH && $past(por_sel) != POR_HIGH) |-> !$past(vlow_raw)); // R3

  AST_DIP_DROPS_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_sel && vlow_raw) |=> !fast_sel); // R7

  AST_POR_FOLLOWS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fast_sel) |=> por_sel == POR_LOW); // R7

  AST_STATUS_FAST_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    fast_sel |-> status == ST_FAST); // R8

endmodule

// File: tb/speed_governor_tb.sv
module speed_governor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic vlow_raw = 1'b1;
  logic pick_top = 1'b0;
  logic [CNT_W-1:0] deb_len = '0;
  logic [2:0] lvd_sel;
  logic [1:0] por_sel;
  logic fast_sel;
  logic [1:0] status;

  int checks = 0;
  int errors = 0;
  logic prev_fast = 1'b0;
  logic [1:0] prev_por = 2'b00;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  speed_governor #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .vlow_raw(vlow_raw),
    .pick_top(pick_top), .deb_len(deb_len), .lvd_sel(lvd_sel),
    .por_sel(por_sel), .fast_sel(fast_sel), .status(status)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    if (rst_n) begin
      checks++;
      if (fast_sel != prev_fast && por_sel != prev_por) begin
        errors++;
        $display("FAIL R6: actual fast %0d->%0d por %0d->%0d expected one change", prev_fast, fast_sel, prev_por, por_sel);
      end
    end
    prev_fast = fast_sel;
    prev_por = por_sel;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; en = 1'b0; vlow_raw = 1'b1;
    tick(); tick();
    rst_n = 1'b1;
  endtask

  task automatic settle_to_thresh(input int n);
    for (int i = 1; i < n; i++) begin
      tick();
      chk(por_sel, 0, "R3 threshold held during debounce");
    end
    tick();
    chk(por_sel, 2, "R3 threshold raised after N clear samples");
    chk(status, 2, "R8 threshold-raised code");
    chk(fast_sel, 0, "R5 no fast on raise edge");
  endtask

  initial begin
    do_reset();
    chk(status, 0, "R1 status");
    chk(por_sel, 0, "R1 threshold");
    chk(fast_sel, 0, "R1 fast");
    chk(lvd_sel, 0, "R1 set point");

    for (int d = 0; d <= 5; d++) begin
      for (int p = 0; p <= 1; p++) begin
        int n;
        n = (d == 0) ? 1 : d;
        deb_len = CNT_W'(d);
        pick_top = p[0];
        do_reset();
        en = 1'b1; vlow_raw = 1'b0;
        tick();
        chk(lvd_sel, 6 + p, "R2 set point code");
        chk(status, 1, "R2 settling code");
        chk(por_sel, 0, "R2 threshold still low");
        settle_to_thresh(n);
        tick();
        chk(fast_sel, 1, "R5 fast after raise");
        chk(status, 3, "R8 fast code");
        vlow_raw = 1'b1;
        tick();
        chk(fast_sel, 0, "R7 dip clears fast");
        chk(por_sel, 2, "R7 threshold held one edge");
        vlow_raw = 1'b0;
        tick();
        chk(por_sel, 0, "R7 threshold lowered");
        chk(status, 1, "R7 back to settling");
        settle_to_thresh(n);
      end
    end

    deb_len = 8'd4;
    pick_top = 1'b0;
    for (int g = 0; g <= 3; g++) begin
      do_reset();
      en = 1'b1; vlow_raw = 1'b0;
      tick();
      for (int i = 0; i < g; i++) begin
        tick();
        chk(por_sel, 0, "R4 before glitch");
      end
      vlow_raw = 1'b1;
      tick();
      chk(por_sel, 0, "R4 glitch sample");
      vlow_raw = 1'b0;
      settle_to_thresh(4);
    end

    deb_len = 8'd1;
    do_reset();
    en = 1'b1; vlow_raw = 1'b0;
    tick();
    tick();
    chk(por_sel, 2, "R10 reached raised");
    vlow_raw = 1'b1;
    tick();
    chk(por_sel, 0, "R10 threshold lowered");
    chk(fast_sel, 0, "R10 no fast");
    chk(status, 1, "R10 settling");

    do_reset();
    en = 1'b1; vlow_raw = 1'b0;
    tick(); tick(); tick();
    chk(fast_sel, 1, "R9 reached fast");
    en = 1'b0;
    tick();
    chk(fast_sel, 0, "R9 fast off first");
    chk(por_sel, 2, "R9 threshold kept");
    tick();
    chk(por_sel, 0, "R9 threshold lowered");
    chk(status, 1, "R9 settling");
    tick();
    chk(status, 0, "R9 slow");
    chk(lvd_sel, 0, "R9 set point cleared");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule